// File: doc/BRIEF.md
# Multi-Cursor Scan-Line Fetch and Overlay Engine

This block drives a set of 32 independent hardware cursors on top of a video stream. Each cursor is a strip of 16 pixels per row, with a 4-bit color index per pixel, so one 64-bit memory word holds a whole cursor row. While horizontal sync is high, the engine walks the cursors in ascending order. For each cursor that is enabled and covers the coming line, it reads that cursor's row from memory into a private line buffer. Cursors that are disabled or off the line are passed over without a memory cycle.

Reads are pipelined, one per clock. Each return is taken exactly two clocks after its request, with no acknowledge. The return is steered to the cursor that issued it, so a full fetch of every cursor fits in a few more than 32 clocks.

During active video, the engine compares the pixel counter with each cursor's left column. It picks the lowest-numbered cursor whose pixel there is opaque, where index 0 is transparent. It then replaces the background pixel with that color index, zero-extended to the pixel width. Palette lookup happens downstream. The fetch is run by a three-state machine: FS_IDLE waits for a rising hsync and moves to FS_SCAN. FS_SCAN visits one cursor per clock and moves to FS_DRAIN after the last cursor. FS_DRAIN waits until no read is in flight and then returns to FS_IDLE.

Top module: `curs_engine`

## Requirements
- R1: After reset no read is requested, no cursor is shown, and pix_out repeats pix_in one clock later with ovl_hit low.
- R2: A rising edge of hsync in FS_IDLE starts a fetch for line pix_y+1. The fetch issues the reads in ascending cursor order, and each read's word address is cur_base + (line − cur_y).
- R3: A cursor is read only when its enable bit is 1 and cur_y ≤ line ≤ cur_y + cur_h − 1. A cursor with height 0 or enable 0 costs no read, and the count of reads equals the count of such cursors.
- R4: At most one read is issued per clock. Every read of a fetch is issued within 34 clocks of the first clock edge that sees hsync high, which is well inside a 70-clock sync period.
- R5: Read data is captured exactly two clocks after the clock edge that samples mem_req. It is stored for the cursor that issued that read.
- R6: A cursor pixel with color index 0 is transparent and leaves the background pixel (or a lower-priority cursor) visible.
- R7: Where several cursors have opaque pixels at the same position, the lowest-numbered cursor wins.
- R8: A cursor covers columns cur_x to cur_x+15. Column cur_x+k shows bits [4k+3:4k] of its fetched word.
- R9: pix_out and ovl_hit reflect the pix_x and pix_in applied one clock earlier. When there is a hit, pix_out is the color index zero-extended; otherwise it is pix_in.
- R10: The start of a fetch drops every line buffer. A cursor not read for the new line shows nothing on it.
- R11: A new rising edge of hsync while a fetch is under way is ignored and does not restart or repeat the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_en | input | NCUR | Per-cursor enable, sampled during the fetch |
| cur_x | input | NCUR x XW | Left column of each cursor |
| cur_y | input | NCUR x YW | Top row of each cursor |
| cur_h | input | NCUR x HW | Height of each cursor in rows |
| cur_base | input | NCUR x AW | Word address of each cursor's top row |
| hsync | input | 1 | Horizontal sync, fetch starts on its rising edge |
| pix_x | input | XW | Current pixel column |
| pix_y | input | YW | Current line (line before the one fetched) |
| pix_in | input | PW | Background pixel |
| mem_req | output | 1 | Read request, one word |
| mem_addr | output | AW | Read word address |
| mem_rdata | input | LW | Read data, valid two clocks after the request |
| pix_out | output | PW | Output pixel |
| ovl_hit | output | 1 | A cursor pixel replaced the background |

## Verification
Reads are sampled on the clock edge where mem_req is high. The bench logs each read's address and cycle, relative to the first edge that sees hsync high. It expects the read for cursor i at offset i+2 at the latest. The memory model returns each word on the second edge after the request, so a read stored at any other cycle shows up as wrong pixels. Pixel inputs are driven on the falling edge, and the result is compared on the next falling edge, one rising edge later. That matches the single output register behind R9.

// File: rtl/curs_pkg.sv
package curs_pkg;
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_SCAN  = 2'd1,
        FS_DRAIN = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/curs_fetch.sv
module curs_fetch
    import curs_pkg::*;
#(
    parameter int NCUR = 32,
    parameter int YW   = 10,
    parameter int HW   = 6,
    parameter int AW   = 16,
    parameter int IW   = $clog2(NCUR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hsync,
    input  logic [YW-1:0]            pix_y,
    input  logic [NCUR-1:0]          cur_en,
    input  logic [NCUR-1:0][YW-1:0]  cur_y,
    input  logic [NCUR-1:0][HW-1:0]  cur_h,
    input  logic [NCUR-1:0][AW-1:0]  cur_base,
    output logic                     mem_req,
    output logic [AW-1:0]            mem_addr,
    output logic                     busy,
    output logic                     line_start,
    output logic                     wr_en,
    output logic [IW-1:0]            wr_idx
);
    fetch_state_t   state, nxt;
    logic           hsync_q;
    logic           rise;
    logic [IW-1:0]  scan_idx;
    logic           last;
    logic [YW-1:0]  ny_q;
    logic [YW-1:0]  row;
    logic           on_line;
    logic           t1_v, t2_v;
    logic [IW-1:0]  t0_i, t1_i, t2_i;

    assign rise    = hsync & ~hsync_q;
    assign last    = (scan_idx == IW'(NCUR - 1));
    assign row     = ny_q - cur_y[scan_idx];
    assign on_line = cur_en[scan_idx] && (ny_q >= cur_y[scan_idx])
                     && (row < YW'(cur_h[scan_idx]));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE:  if (rise) nxt = FS_SCAN;
            FS_SCAN:  if (last) nxt = FS_DRAIN;
            FS_DRAIN: if (!mem_req && !t1_v && !t2_v) nxt = FS_IDLE;
            default:  nxt = FS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_q  <= 1'b0;
            scan_idx <= '0;
            ny_q     <= '0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            t0_i     <= '0;
            t1_v     <= 1'b0;
            t1_i     <= '0;
            t2_v     <= 1'b0;
            t2_i     <= '0;
        end else begin
            hsync_q <= hsync;
            if (state == FS_IDLE && rise) begin
                ny_q     <= pix_y + YW'(1);
                scan_idx <= '0;
            end else if (state == FS_SCAN) begin
                scan_idx <= scan_idx + IW'(1);
            end
            mem_req  <= (state == FS_SCAN) && on_line;
            mem_addr <= ((state == FS_SCAN) && on_line)
                        ? cur_base[scan_idx] + AW'(row) : '0;
            t0_i     <= scan_idx;
            t1_v     <= mem_req;
            t1_i     <= t0_i;
            t2_v     <= t1_v;
            t2_i     <= t1_i;
        end
    end

    assign busy       = (state != FS_IDLE);
    assign line_start = (state == FS_IDLE) && rise;
    assign wr_en      = t2_v;
    assign wr_idx     = t2_i;
endmodule

// File: rtl/curs_linebuf.sv
module curs_linebuf #(
    parameter int NCUR = 32,
    parameter int LW   = 64,
    parameter int IW   = $clog2(NCUR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [LW-1:0]            wr_data,
    output logic [NCUR-1:0][LW-1:0]  line_data,
    output logic [NCUR-1:0]          line_vld
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_vld <= '0;
        end else begin
            if (clr)   line_vld <= '0;
            if (wr_en) line_vld[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) line_data[wr_idx] <= wr_data;
    end
endmodule

// File: rtl/curs_overlay.sv
module curs_overlay #(
    parameter int NCUR = 32,
    parameter int XW   = 10,
    parameter int PW   = 16,
    parameter int CW   = 16,
    parameter int BPP  = 4,
    parameter int LW   = CW * BPP,
    parameter logic [BPP-1:0] TRANSP = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCUR-1:0][XW-1:0]  cur_x,
    input  logic [NCUR-1:0][LW-1:0]  line_data,
    input  logic [NCUR-1:0]          line_vld,
    input  logic [XW-1:0]            pix_x,
    input  logic [PW-1:0]            pix_in,
    output logic [PW-1:0]            pix_out,
    output logic                     ovl_hit
);
    localparam int CXB = $clog2(CW);
    localparam int BB  = $clog2(BPP);

    logic [NCUR-1:0]          opq;
    logic [NCUR-1:0][BPP-1:0] nib;
    logic                     hit_c;
    logic [BPP-1:0]           col_c;

    for (genvar i = 0; i < NCUR; i++) begin : g_cur
        logic [XW-1:0] dx;
        logic          inr;
        assign dx     = pix_x - cur_x[i];
        assign inr    = (pix_x >= cur_x[i]) && (dx < XW'(CW));
        assign nib[i] = line_data[i][{dx[CXB-1:0], {BB{1'b0}}} +: BPP];
        assign opq[i] = line_vld[i] && inr && (nib[i] != TRANSP);
    end

    // lowest index wins: scan downward so it is assigned last
    always_comb begin
        hit_c = 1'b0;
        col_c = '0;
        for (int i = NCUR - 1; i >= 0; i--) begin
            if (opq[i]) begin
                hit_c = 1'b1;
                col_c = nib[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out <= '0;
            ovl_hit <= 1'b0;
        end else begin
            pix_out <= hit_c ? PW'(col_c) : pix_in;
            ovl_hit <= hit_c;
        end
    end
endmodule

// File: rtl/curs_engine.sv
module curs_engine #(
    parameter int NCUR = 32,
    parameter int XW   = 10,
    parameter int YW   = 10,
    parameter int HW   = 6,
    parameter int AW   = 16,
    parameter int PW   = 16,
    parameter int CW   = 16,
    parameter int BPP  = 4,
    parameter int LW   = CW * BPP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCUR-1:0]          cur_en,
    input  logic [NCUR-1:0][XW-1:0]  cur_x,
    input  logic [NCUR-1:0][YW-1:0]  cur_y,
    input  logic [NCUR-1:0][HW-1:0]  cur_h,
    input  logic [NCUR-1:0][AW-1:0]  cur_base,
    input  logic                     hsync,
    input  logic [XW-1:0]            pix_x,
    input  logic [YW-1:0]            pix_y,
    input  logic [PW-1:0]            pix_in,
    output logic                     mem_req,
    output logic [AW-1:0]            mem_addr,
    input  logic [LW-1:0]            mem_rdata,
    output logic [PW-1:0]            pix_out,
    output logic                     ovl_hit
);
    localparam int IW = $clog2(NCUR);

    logic                     fetch_busy;
    logic                     line_start;
    logic                     wr_en;
    logic [IW-1:0]            wr_idx;
    logic [NCUR-1:0][LW-1:0]  line_data;
    logic [NCUR-1:0]          line_vld;

    curs_fetch #(
        .NCUR(NCUR), .YW(YW), .HW(HW), .AW(AW), .IW(IW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .pix_y(pix_y),
        .cur_en(cur_en), .cur_y(cur_y), .cur_h(cur_h), .cur_base(cur_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .busy(fetch_busy),
        .line_start(line_start), .wr_en(wr_en), .wr_idx(wr_idx)
    );

    curs_linebuf #(
        .NCUR(NCUR), .LW(LW), .IW(IW)
    ) u_lbuf (
        .clk(clk), .rst_n(rst_n), .clr(line_start), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(mem_rdata),
        .line_data(line_data), .line_vld(line_vld)
    );

    curs_overlay #(
        .NCUR(NCUR), .XW(XW), .PW(PW), .CW(CW), .BPP(BPP), .LW(LW),
        .TRANSP('0)
    ) u_ovl (
        .clk(clk), .rst_n(rst_n), .cur_x(cur_x), .line_data(line_data),
        .line_vld(line_vld), .pix_x(pix_x), .pix_in(pix_in),
        .pix_out(pix_out), .ovl_hit(ovl_hit)
    );
endmodule

// File: rtl/curs_engine_chk.sv
module curs_engine_chk #(
    parameter int NCUR = 32,
    parameter int PW   = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsync,
    input logic          mem_req,
    input logic          fetch_busy,
    input logic          wr_en,
    input logic [PW-1:0] pix_in,
    input logic [PW-1:0] pix_out,
    input logic          ovl_hit
);
    int busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !fetch_busy) busy_cnt <= 0;
        else                       busy_cnt <= busy_cnt + 1;
    end

    // R4: reads only while a fetch is under way
    p_req_in_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> fetch_busy);

    // R4: a fetch ends within its window
    p_fetch_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= NCUR + 4);

    // R5: every request is written back exactly two clocks later
    p_return_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_req, 2) |-> wr_en);

    // R5: no write without a request two clocks earlier
    p_no_stray_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(mem_req, 2));

    // R2: a fetch starts only after hsync was seen high
    p_start_on_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_busy) |-> $past(hsync));

    // R9: without a hit the background passes with one clock delay
    p_bg_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_hit |-> (pix_out == $past(pix_in)));

    // R4: the drain leaves no request behind
    p_drain_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fetch_busy) |-> !mem_req);
endmodule

bind curs_engine curs_engine_chk #(.NCUR(NCUR), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .mem_req(mem_req),
    .fetch_busy(fetch_busy), .wr_en(wr_en), .pix_in(pix_in),
    .pix_out(pix_out), .ovl_hit(ovl_hit)
);

// File: tb/sim_curs_engine.sv
module sim_curs_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NCUR = 32;
    localparam int XW = 10, YW = 10, HW = 6, AW = 16, PW = 16;
    localparam int CW = 16, BPP = 4, LW = 64;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NCUR-1:0]          cur_en = '0;
    logic [NCUR-1:0][XW-1:0]  cur_x = '0;
    logic [NCUR-1:0][YW-1:0]  cur_y = '0;
    logic [NCUR-1:0][HW-1:0]  cur_h = '0;
    logic [NCUR-1:0][AW-1:0]  cur_base = '0;
    logic                     hsync = 1'b0;
    logic [XW-1:0]            pix_x = '0;
    logic [YW-1:0]            pix_y = '0;
    logic [PW-1:0]            pix_in = '0;
    logic                     mem_req;
    logic [AW-1:0]            mem_addr;
    logic [LW-1:0]            mem_rdata = '0;
    logic [PW-1:0]            pix_out;
    logic                     ovl_hit;

    curs_engine u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: 256 words, data on the second edge after the request edge
    logic [LW-1:0] mem [0:255];
    logic [LW-1:0] d1 = '0;
    always @(posedge clk) begin
        d1        <= mem_req ? mem[mem_addr[7:0]] : '0;
        mem_rdata <= d1;
    end

    int cyc = 0;
    int n_req = 0;
    bit log_on = 0;
    logic [AW-1:0] req_addr [0:63];
    int            req_cyc  [0:63];
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (log_on && mem_req && n_req < 64) begin
            req_addr[n_req] = mem_addr;
            req_cyc[n_req]  = cyc;
            n_req = n_req + 1;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_on(input int i, input logic [YW-1:0] ny);
        logic [YW-1:0] r;
        r = ny - cur_y[i];
        return cur_en[i] && (ny >= cur_y[i]) && (r < YW'(cur_h[i]));
    endfunction

    function automatic logic [AW-1:0] exp_addr(input int i, input logic [YW-1:0] ny);
        logic [YW-1:0] r;
        r = ny - cur_y[i];
        return cur_base[i] + AW'(r);
    endfunction

    // expected pixel: lowest opaque cursor, index 0 transparent
    function automatic logic [PW:0] exp_pix(input logic [XW-1:0] x,
                                            input logic [PW-1:0] bg,
                                            input logic [YW-1:0] ny);
        for (int i = 0; i < NCUR; i++) begin
            if (exp_on(i, ny) && x >= cur_x[i] && (x - cur_x[i]) < XW'(CW)) begin
                logic [LW-1:0] w;
                logic [3:0] k;
                logic [BPP-1:0] n;
                w = mem[exp_addr(i, ny) % 256];
                k = 4'(x - cur_x[i]);
                n = w[k*4 +: 4];
                if (n != 4'd0) return {1'b1, PW'(n)};
            end
        end
        return {1'b0, bg};
    endfunction

    // one line: fetch during hsync, then sweep columns 0..255
    task automatic run_line(input int L, input bit glitch);
        logic [YW-1:0] ny;
        int ne;
        logic [AW-1:0] ea [0:63];
        int h_cyc;
        ny = YW'(L + 1);
        n_req = 0;
        log_on = 1;
        @(negedge clk);
        pix_y = YW'(L);
        hsync = 1'b1;
        h_cyc = cyc;
        if (glitch) begin
            repeat (10) @(negedge clk);
            hsync = 1'b0;
            @(negedge clk);
            hsync = 1'b1;
        end
        repeat (60) @(negedge clk);
        hsync = 1'b0;
        log_on = 0;
        ne = 0;
        for (int i = 0; i < NCUR; i++)
            if (exp_on(i, ny)) begin ea[ne] = exp_addr(i, ny); ne++; end
        // R3 / R11: read count
        chk(n_req == ne, "R3", glitch ? "R11 read count after resync" : "read count",
            n_req, ne);
        for (int k = 0; k < ne && k < n_req; k++)
            chk(req_addr[k] == ea[k], "R2", "read address in order", req_addr[k], ea[k]);
        if (n_req > 0)
            chk(req_cyc[n_req-1] - h_cyc <= NCUR + 2, "R4", "last read offset",
                req_cyc[n_req-1] - h_cyc, NCUR + 2);
        pix_y = ny;
        for (int x = 0; x < 256; x++) begin
            logic [PW:0] e;
            logic [PW-1:0] bg;
            bg = PW'($urandom);
            pix_x = XW'(x);
            pix_in = bg;
            e = exp_pix(XW'(x), bg, ny);
            @(negedge clk);
            // R6 R7 R8 R9 R10 R5: pixel content after one clock
            chk(pix_out == e[PW-1:0] && ovl_hit == e[PW], "R8", "pixel R6/R7/R9",
                {ovl_hit, pix_out}, e);
        end
    endtask

    task automatic all_off();
        cur_en = '0; cur_x = '0; cur_y = '0; cur_h = '0; cur_base = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) mem[i] = {$urandom, $urandom};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(mem_req == 1'b0, "R1", "no read after reset", mem_req, 0);
        pix_in = 16'hBEEF; pix_x = 10'd5;
        @(negedge clk);
        chk(pix_out == 16'hBEEF && !ovl_hit, "R1", "background after reset", pix_out, 16'hBEEF);

        // directed R6 / R7: two overlapping cursors at one place
        all_off();
        mem[10] = 64'h0000_1111_0000_1111;
        mem[11] = 64'h2222_2222_2222_2222;
        cur_en[3] = 1; cur_x[3] = 10'd40; cur_y[3] = 10'd21; cur_h[3] = 6'd1; cur_base[3] = 16'd10;
        cur_en[5] = 1; cur_x[5] = 10'd40; cur_y[5] = 10'd21; cur_h[5] = 6'd1; cur_base[5] = 16'd11;
        run_line(20, 0);
        pix_x = 10'd40; @(negedge clk);
        chk(pix_out == 16'd1, "R7", "lower cursor wins", pix_out, 1);
        pix_x = 10'd44; @(negedge clk);
        chk(pix_out == 16'd2, "R6", "transparent shows next cursor", pix_out, 2);
        pix_x = 10'd56; pix_in = 16'h1234; @(negedge clk);
        chk(pix_out == 16'h1234, "R8", "column past right edge", pix_out, 16'h1234);

        // directed R10: next line has no cursor
        run_line(21, 0);

        // directed R3: everything on except disabled and zero height
        all_off();
        for (int i = 0; i < NCUR; i++) begin
            cur_en[i] = 1; cur_y[i] = 10'd100; cur_h[i] = 6'd4;
            cur_x[i] = XW'(i * 7); cur_base[i] = AW'(i * 5);
        end
        cur_en[7] = 0; cur_h[8] = 6'd0;
        run_line(101, 0);
        // R11: resync inside a fetch
        run_line(102, 1);

        // random lines
        for (int t = 0; t < 40; t++) begin
            int L;
            L = 200 + t;
            all_off();
            for (int i = 0; i < NCUR; i++) begin
                cur_en[i]   = ($urandom_range(0, 9) < 6);
                cur_x[i]    = XW'($urandom_range(0, 220));
                cur_y[i]    = YW'(L + 1 - $urandom_range(0, 20));
                cur_h[i]    = HW'($urandom_range(0, 20));
                cur_base[i] = AW'($urandom_range(0, 220));
            end
            run_line(L, 0);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule